// File: doc/BRIEF.md
# Multi-mode programmable logic cell

This block is one configurable logic cell for a fine-grained programmable fabric. It contains a 16-entry lookup table, a carry output, a cascade output and one storage flop. A static configuration word selects one of four datapaths:

- plain logic with a wide-function merge;
- arithmetic, with split result and carry tables;
- an up/down counter bit;
- a counter bit with synchronous clear.

Several cells are chained through the carry and cascade pins to build adders, counters and wide decoders.

The configuration word is written in one cycle through a parallel port. The flop holds its value during that cycle. The flop also has active-low asynchronous clear and preset pins, which can force a counter value without using the lookup table.

Top module: `plc_cell`

## Requirements
- R1: While rst_ni is low, the configuration word is zero and the flop is 0. With that zero word the cell is in plain mode with an all-zero table, so out_o, carry_o and casc_o are all 0.
- R2: The configuration word has these fields:
  - table contents in bits [15:0];
  - mode in bits [17:16], where 0 = plain, 1 = arithmetic, 2 = up/down counter and 3 = clearable counter;
  - third-input select in bit 18;
  - cascade merge type in bit 19;
  - output select in bit 20.

  In plain mode the table result is the table bit at index {data_i[3], x, data_i[1], data_i[0]}.
- R3: In plain mode, x in that index is data_i[2] when bit 18 is 0 and carry_i when bit 18 is 1.
- R4: In plain and arithmetic modes, the merged value is the table result AND casc_i when bit 19 is 0, and the table result OR casc_i when bit 19 is 1. casc_o carries the merged value.
- R5: out_o is the merged or counter value when bit 20 is 0 and the flop output when bit 20 is 1. In either case the flop loads the merged or counter value on each rising clock edge.
- R6: In arithmetic mode, let i = {carry_i, data_i[1], data_i[0]}. The result is table bit i and carry_o is table bit 8+i.
- R7: In up/down counter mode, the data pins have these roles:
  - data_i[3] is an active-low load;
  - data_i[0] is the load value;
  - data_i[2] is the enable;
  - data_i[1] is the direction.

  A low load selects data_i[0] as the next value. Otherwise the next value is table bit {carry_i, data_i[2], q}, and carry_o is table bit 8+{carry_i, data_i[1], q}.
- R8: In clearable counter mode, casc_i acts as a synchronous clear and forces the next value to 0, even over a load. carry_o is table bit 8+{carry_i, 1, q}.
- R9: A low clr_ni forces the flop to 0 at once. A low pre_ni with clr_ni high forces it to 1. When both are low, the clear wins.
- R10: While cfg_we_i is high, the flop keeps its value. The new word takes effect from the next cycle.
- R11: carry_o is 0 in plain mode, and casc_o is 0 in both counter modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 21 | Configuration word |
| data_i | input | 4 | Four data inputs |
| carry_i | input | 1 | Carry from the lower cell |
| casc_i | input | 1 | Cascade input; synchronous clear in clearable counter mode |
| clr_ni | input | 1 | Asynchronous clear of the flop, active low |
| pre_ni | input | 1 | Asynchronous preset of the flop, active low |
| out_o | output | 1 | Cell result |
| carry_o | output | 1 | Carry to the higher cell |
| casc_o | output | 1 | Cascade to the next cell |

## Verification
Two pairs of functions can fall in the same cycle.

- **Synchronous clear and load (clearable counter mode).** The bench raises casc_i in random cycles while the active-low load is also asserted with random load values. The reference model expects 0 in every such cycle, on a single cell and on a four-cell chained counter.
- **Configuration write and pending load.** A configuration write is issued while the data pins request a load of the opposite value. The model expects the flop value to be kept through the write cycle and the new word to act only from the following edge.

The asynchronous clear and preset are also asserted together, and clear must win.

// File: rtl/plc_pkg.sv
package plc_pkg;
  localparam int unsigned LutIn  = 4;
  localparam int unsigned LutSz  = 1 << LutIn;
  localparam int unsigned HalfIn = LutIn - 1;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_ARITH  = 2'd1,
    MODE_UPDN   = 2'd2,
    MODE_CLRCNT = 2'd3
  } mode_e;

  typedef struct packed {
    logic             reg_out;
    logic             casc_or;
    logic             use_cin;
    mode_e            mode;
    logic [LutSz-1:0] lut;
  } cfg_t;

  localparam int unsigned CfgW = $bits(cfg_t);
endpackage

// File: rtl/plc_lut.sv
module plc_lut
  import plc_pkg::*;
(
  input  logic [LutSz-1:0]  lut_i,
  input  logic [LutIn-1:0]  full_idx_i,
  input  logic [HalfIn-1:0] lo_idx_i,
  input  logic [HalfIn-1:0] hi_idx_i,
  output logic              full_o,
  output logic              lo_o,
  output logic              hi_o
);
  // lower half drives the result, upper half the carry
  assign full_o = lut_i[full_idx_i];
  assign lo_o   = lut_i[{1'b0, lo_idx_i}];
  assign hi_o   = lut_i[{1'b1, hi_idx_i}];
endmodule

// File: rtl/plc_dpath.sv
module plc_dpath
  import plc_pkg::*;
(
  input  cfg_t             cfg_i,
  input  logic [LutIn-1:0] data_i,
  input  logic             carry_i,
  input  logic             casc_i,
  input  logic             q_i,
  output logic             comb_o,
  output logic             carry_o,
  output logic             casc_o
);
  logic             in3;
  logic [LutIn-1:0] full_idx;
  logic [HalfIn-1:0] lo_idx, hi_idx;
  logic             full_v, lo_v, hi_v;
  logic             fn, merged, is_cnt, ld_mux, sclr;

  assign in3      = cfg_i.use_cin ? carry_i : data_i[2];
  assign full_idx = {data_i[3], in3, data_i[1], data_i[0]};

  always_comb begin
    unique case (cfg_i.mode)
      MODE_NORMAL, MODE_ARITH: begin
        lo_idx = {carry_i, data_i[1], data_i[0]};
        hi_idx = {carry_i, data_i[1], data_i[0]};
      end
      MODE_UPDN: begin
        lo_idx = {carry_i, data_i[2], q_i};
        hi_idx = {carry_i, data_i[1], q_i};
      end
      default: begin
        // direction pinned to up
        lo_idx = {carry_i, data_i[2], q_i};
        hi_idx = {carry_i, 1'b1, q_i};
      end
    endcase
  end

  plc_lut u_lut (
    .lut_i     (cfg_i.lut),
    .full_idx_i(full_idx),
    .lo_idx_i  (lo_idx),
    .hi_idx_i  (hi_idx),
    .full_o    (full_v),
    .lo_o      (lo_v),
    .hi_o      (hi_v)
  );

  assign fn     = (cfg_i.mode == MODE_NORMAL) ? full_v : lo_v;
  assign merged = cfg_i.casc_or ? (fn | casc_i) : (fn & casc_i);

  assign is_cnt = cfg_i.mode[1];
  assign ld_mux = data_i[3] ? lo_v : data_i[0];
  assign sclr   = (cfg_i.mode == MODE_CLRCNT) & casc_i;

  assign comb_o  = is_cnt ? (ld_mux & ~sclr) : merged;
  assign carry_o = (cfg_i.mode == MODE_NORMAL) ? 1'b0 : hi_v;
  assign casc_o  = is_cnt ? 1'b0 : merged;
endmodule

// File: rtl/plc_reg.sv
module plc_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  input  logic pre_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni or negedge pre_ni) begin
    if (!rst_ni || !clr_ni) q_o <= 1'b0;
    else if (!pre_ni)       q_o <= 1'b1;
    else if (en_i)          q_o <= d_i;
  end
endmodule

// File: rtl/plc_cell.sv
module plc_cell
  import plc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [CfgW-1:0] cfg_data_i,
  input  logic [LutIn-1:0] data_i,
  input  logic            carry_i,
  input  logic            casc_i,
  input  logic            clr_ni,
  input  logic            pre_ni,
  output logic            out_o,
  output logic            carry_o,
  output logic            casc_o
);
  cfg_t cfg_q;
  logic q, comb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_t'(cfg_data_i);
  end

  plc_dpath u_dpath (
    .cfg_i  (cfg_q),
    .data_i (data_i),
    .carry_i(carry_i),
    .casc_i (casc_i),
    .q_i    (q),
    .comb_o (comb),
    .carry_o(carry_o),
    .casc_o (casc_o)
  );

  plc_reg u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_ni(clr_ni),
    .pre_ni(pre_ni),
    .en_i  (~cfg_we_i),
    .d_i   (comb),
    .q_o   (q)
  );

  assign out_o = cfg_q.reg_out ? q : comb;
endmodule

// File: rtl/plc_cell_chk.sv
module plc_cell_chk
  import plc_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_we_i,
  input logic [LutIn-1:0] data_i,
  input logic            casc_i,
  input logic            clr_ni,
  input logic            pre_ni,
  input logic            carry_o,
  input logic            q,
  input cfg_t            cfg_q
);
  // R9
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> !q);

  // R9
  pre_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !pre_ni) |-> q);

  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && clr_ni && pre_ni) |=> (q == $past(q)) || !clr_ni || !pre_ni);

  // R7
  updn_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == MODE_UPDN && !data_i[3] && !cfg_we_i && clr_ni && pre_ni)
    |=> (q == $past(data_i[0])) || !clr_ni || !pre_ni);

  // R8
  sync_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == MODE_CLRCNT && casc_i && !cfg_we_i && clr_ni && pre_ni)
    |=> !q || !pre_ni);

  // R11
  normal_nocarry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == MODE_NORMAL) |-> !carry_o);
endmodule

bind plc_cell plc_cell_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cfg_we_i(cfg_we_i),
  .data_i  (data_i),
  .casc_i  (casc_i),
  .clr_ni  (clr_ni),
  .pre_ni  (pre_ni),
  .carry_o (carry_o),
  .q       (q),
  .cfg_q   (cfg_q)
);

// File: tb/tb_plc_cell.sv
`timescale 1ns/1ps
module tb_plc_cell;
  import plc_pkg::*;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  // single cell
  logic            cfg_we = 1'b0;
  logic [CfgW-1:0] cfg_d = '0;
  logic [3:0]      d = '0;
  logic            cin = 1'b0, casc = 1'b1, clr_n = 1'b1, pre_n = 1'b1;
  logic            out_o, carry_o, casc_o;

  plc_cell dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_data_i(cfg_d),
    .data_i(d), .carry_i(cin), .casc_i(casc), .clr_ni(clr_n), .pre_ni(pre_n),
    .out_o(out_o), .carry_o(carry_o), .casc_o(casc_o)
  );

  // chain of cells
  logic            ccfg_we = 1'b0;
  logic [CfgW-1:0] ccfg = '0;
  logic [3:0]      cd [NC];
  logic            c0 = 1'b0, ccasc = 1'b1;
  wire  [NC:0]     cc;
  wire  [NC-1:0]   cq, cs;
  assign cc[0] = c0;

  for (genvar g = 0; g < NC; g++) begin : g_chain
    plc_cell u_c (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(ccfg_we), .cfg_data_i(ccfg),
      .data_i(cd[g]), .carry_i(cc[g]), .casc_i(ccasc), .clr_ni(1'b1), .pre_ni(1'b1),
      .out_o(cq[g]), .carry_o(cc[g+1]), .casc_o(cs[g])
    );
  end

  int n_chk = 0, n_bad = 0;
  logic [CfgW-1:0] mcfg = '0;
  logic            mq = 1'b0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic void eval(output logic ec, output logic ey, output logic es);
    int m, i, fi;
    logic f, mg;
    logic [15:0] l;
    l = mcfg[15:0];
    m = int'(mcfg[17:16]);
    if (m < 2) begin
      if (m == 0) begin
        fi = int'(d[0]) + 2*int'(d[1]) + 4*int'(mcfg[18] ? cin : d[2]) + 8*int'(d[3]);
        f  = l[fi];
        ey = 1'b0;
      end else begin
        i  = int'(d[0]) + 2*int'(d[1]) + 4*int'(cin);
        f  = l[i];
        ey = l[8+i];
      end
      mg = mcfg[19] ? (f | casc) : (f & casc);
      ec = mg;
      es = mg;
    end else begin
      i  = int'(mq) + 2*int'(d[2]) + 4*int'(cin);
      ec = d[3] ? l[i] : d[0];
      if (m == 3 && casc) ec = 1'b0;
      ey = l[8 + int'(mq) + 2*((m == 2) ? int'(d[1]) : 1) + 4*int'(cin)];
      es = 1'b0;
    end
  endfunction

  // called just after a falling edge with inputs already driven
  task automatic tick(input string tag);
    logic ec, ey, es, eo;
    #2;
    eval(ec, ey, es);
    eo = mcfg[20] ? mq : ec;
    chk({tag, " out"}, 32'(out_o), 32'(eo));
    chk({tag, " carry"}, 32'(carry_o), 32'(ey));
    chk({tag, " casc"}, 32'(casc_o), 32'(es));
    @(posedge clk);
    if (cfg_we)      mcfg = cfg_d;
    else if (!clr_n) mq = 1'b0;
    else if (!pre_n) mq = 1'b1;
    else             mq = ec;
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [CfgW-1:0] w);
    cfg_we = 1'b1; cfg_d = w;
    tick("R10 cfg");
    cfg_we = 1'b0;
  endtask

  task automatic rand_in(input bit cnt_mode);
    d    = 4'($urandom);
    cin  = 1'($urandom);
    casc = 1'($urandom);
    if (cnt_mode && ($urandom % 4 != 0)) d[3] = 1'b1;
  endtask

  task automatic write_chain(input logic [CfgW-1:0] w);
    ccfg_we = 1'b1; ccfg = w;
    @(negedge clk);
    ccfg_we = 1'b0;
  endtask

  localparam logic [15:0] LUT_ADD = 16'hE896;
  localparam logic [15:0] LUT_CNT = 16'h906A;

  initial begin
    logic [15:0] tl;
    int cnt, ld, en, dir, ldn, clr;
    for (int g = 0; g < NC; g++) cd[g] = '0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 out", 32'(out_o), 32'd0);
    chk("R1 carry", 32'(carry_o), 32'd0);
    chk("R1 casc", 32'(casc_o), 32'd0);
    chk("R1 chain", 32'(cq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // plain mode: every select/merge/output variant
    for (int v = 0; v < 8; v++) begin
      tl = 16'($urandom);
      write_cfg({1'(v >> 2), 1'(v >> 1), 1'(v), 2'd0, tl});
      for (int k = 0; k < 40; k++) begin
        rand_in(0);
        tick("R2/R3/R4/R5/R11 plain");
      end
    end

    // arithmetic mode
    for (int v = 0; v < 4; v++) begin
      write_cfg({1'(v >> 1), 1'(v), 1'b0, 2'd1, 16'($urandom)});
      for (int k = 0; k < 40; k++) begin
        rand_in(0);
        tick("R6 arith");
      end
    end

    // up/down counter bit
    write_cfg({1'b1, 1'b0, 1'b0, 2'd2, LUT_CNT});
    for (int k = 0; k < 80; k++) begin
      rand_in(1);
      tick("R7/R11 updn");
    end
    write_cfg({1'b0, 1'b0, 1'b0, 2'd2, 16'($urandom)});
    for (int k = 0; k < 40; k++) begin
      rand_in(1);
      tick("R7 updn raw");
    end

    // clearable counter: clear and load collide
    write_cfg({1'b1, 1'b0, 1'b0, 2'd3, LUT_CNT});
    for (int k = 0; k < 80; k++) begin
      rand_in(1);
      if (k % 5 == 0) begin d[3] = 1'b0; d[0] = 1'b1; casc = 1'b1; end
      tick("R8/R11 clrcnt");
    end

    // asynchronous clear and preset
    write_cfg({1'b1, 1'b0, 1'b0, 2'd2, LUT_CNT});
    d = 4'b0000; cin = 1'b0;
    clr_n = 1'b0; mq = 1'b0; tick("R9 clear");
    clr_n = 1'b1; pre_n = 1'b0; mq = 1'b1; tick("R9 preset");
    clr_n = 1'b0; mq = 1'b0; tick("R9 both");
    clr_n = 1'b1; pre_n = 1'b1; d = 4'b1000; tick("R9 release");

    // configuration write during a pending load
    d = 4'b0001; tick("R10 set");
    d = 4'b0000;
    write_cfg({1'b1, 1'b0, 1'b0, 2'd0, 16'h0000});
    chk("R10 hold", 32'(out_o), 32'd1);
    tick("R10 after");
    tick("R10 after2");

    // chained adder
    write_chain({1'b0, 1'b0, 1'b0, 2'd1, LUT_ADD});
    ccasc = 1'b1;
    for (int k = 0; k < 60; k++) begin
      int a, b, s;
      a = int'($urandom % 16); b = int'($urandom % 16);
      c0 = 1'($urandom);
      for (int g = 0; g < NC; g++) cd[g] = {2'b00, 1'(b >> g), 1'(a >> g)};
      s = a + b + int'(c0);
      #2;
      chk("R6 chain sum", 32'(cq), 32'(s % 16));
      chk("R6 chain cout", 32'(cc[NC]), 32'(s / 16));
      @(negedge clk);
    end

    // chained up/down counter
    write_chain({1'b1, 1'b0, 1'b0, 2'd2, LUT_CNT});
    c0 = 1'b1; ccasc = 1'b0; cnt = 0;
    for (int k = 0; k < 120; k++) begin
      en = int'($urandom % 4 != 0); dir = int'($urandom % 2);
      ldn = int'($urandom % 8 != 0); ld = int'($urandom % 16);
      if (k == 0) begin ldn = 0; ld = 14; end
      for (int g = 0; g < NC; g++) cd[g] = {1'(ldn), 1'(en), 1'(dir), 1'(ld >> g)};
      @(posedge clk);
      if (ldn == 0)  cnt = ld;
      else if (en != 0) cnt = (dir != 0) ? (cnt + 1) % 16 : (cnt + 15) % 16;
      @(negedge clk); #2;
      chk("R7 chain count", 32'(cq), 32'(cnt));
    end

    // chained clearable counter
    write_chain({1'b1, 1'b0, 1'b0, 2'd3, LUT_CNT});
    for (int k = 0; k < 120; k++) begin
      en = int'($urandom % 4 != 0);
      ldn = int'($urandom % 8 != 0); ld = int'($urandom % 16);
      clr = int'($urandom % 6 == 0);
      if (k % 17 == 3) begin clr = 1; ldn = 0; ld = 9; end
      for (int g = 0; g < NC; g++) cd[g] = {1'(ldn), 1'(en), 1'($urandom), 1'(ld >> g)};
      ccasc = 1'(clr);
      @(posedge clk);
      if (clr != 0)      cnt = 0;
      else if (ldn == 0) cnt = ld;
      else if (en != 0)  cnt = (cnt + 1) % 16;
      @(negedge clk); #2;
      chk("R8 chain count", 32'(cq), 32'(cnt));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule